// File: doc/BRIEF.md
# Resizable Circular Issue Queue

This block is an out-of-order instruction issue queue kept as a circular FIFO. Instructions come in at the tail and issue from anywhere inside the window. Entries are never compacted. When the oldest entries have gone, the head skips over the freed slots. The storage is split into equal portions. A window register, counted in portions, places a limit pointer that many portions ahead of the head. When the head advances, the limit advances with it.

Empty slots past the limit are gated off. They do no result-tag comparison, and this is where the block saves switching power. Occupied slots always keep comparing, so shrinking the window never loses a wakeup. An external policy sends single-portion grow and shrink pulses. The block reports three things back:
- which portion holds the last slot of the window;
- the current occupancy;
- a stall flag.

Dispatch is a valid/ready handshake carrying up to four instructions, packed from lane 0. A group is accepted only on a cycle where `dsp_valid` and `dsp_ready` are both high. `dsp_ready` does not depend on `dsp_valid`. Issue is also valid/ready: `iss_valid` shows the oldest ready entries whatever the value of `iss_ready`, and they leave the queue only on a cycle where `iss_ready` is high. Up to four result tags are broadcast each cycle.

Top module: `rsz_issue_queue`

## Requirements
- R1: After reset the block is in this state: occupancy 0, `dsp_ready` 1, `stall` 0, the window is all 16 portions, `youngest_portion` is 15, and every bit of `wake_en` is 1.
- R2: On an accepted dispatch, lanes 0 to `dsp_cnt`-1 are written at consecutive slots from the tail, in lane order. Occupancy then rises by `dsp_cnt`.
- R3: Each cycle up to four entries whose sources are both ready are offered on the issue lanes, oldest first. Lane 0 carries the oldest, and the valid lanes are contiguous from lane 0. An entry leaves the queue only on a cycle where `iss_ready` is 1.
- R4: A source becomes ready when a broadcast lane with `bc_valid` set carries the same 7-bit tag. The entry can issue from the next cycle.
- R5: A source dispatched in the same cycle as a matching broadcast is recorded as ready.
- R6: A `grow` pulse widens the window by one portion, up to 16. A `shrink` pulse narrows it by one portion, down to 1. Both pulses in the same cycle change nothing. `youngest_portion` is ((head + 8*window - 1) mod 128) / 8.
- R7: `wake_en[i]` is 1 exactly when slot i lies within the window starting at the head, or slot i is occupied. A slot with `wake_en` 0 keeps its ready bits unchanged.
- R8: `dsp_ready` is 1 exactly when occupancy + 4 ≤ 8*window, and `stall` is its inverse. A group offered while `dsp_ready` is 0 is not taken.
- R9: Shrinking the window never removes entries. Occupied slots beyond the limit keep waking up and still issue.
- R10: When the oldest entries leave, the head skips the freed slots. The limit, `youngest_portion` and the gated region move with the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dsp_valid | input | 1 | Dispatch group offered |
| dsp_ready | output | 1 | Queue can take a group of four |
| dsp_cnt | input | 3 | Number of used lanes, packed from lane 0 |
| dsp_src1 | input | 28 | First source tag per lane (lane k at bits 7k+6:7k) |
| dsp_src1_rdy | input | 4 | First source already ready, per lane |
| dsp_src2 | input | 28 | Second source tag per lane |
| dsp_src2_rdy | input | 4 | Second source already ready, per lane |
| dsp_dst | input | 28 | Destination tag per lane |
| bc_valid | input | 4 | Result broadcast lane valid |
| bc_tag | input | 28 | Result broadcast tags |
| iss_ready | input | 1 | Execution side accepts the offered issues |
| iss_valid | output | 4 | Issue lane valid, contiguous from lane 0 |
| iss_dst | output | 28 | Destination tag of each issued entry |
| grow | input | 1 | Widen window by one portion |
| shrink | input | 1 | Narrow window by one portion |
| youngest_portion | output | 4 | Portion holding the last slot of the window |
| stall | output | 1 | Dispatch blocked |
| occupancy | output | 8 | Slots from head to tail |
| wake_en | output | 128 | Per-slot wakeup-compare enable |

## Verification
Two things can happen to one instruction in the same cycle: dispatch writes it, and a broadcast carries the tag it is waiting for. The bench provokes this by dispatching an entry whose source matches the tag on a broadcast lane that is active on that exact edge. It then judges the result by whether that destination issues on the next cycle. A second collision is a shrink while slots past the new limit are occupied. In that case a later broadcast must still wake the stranded entry, and the scoreboard must still see it issue in age order.

// File: rtl/iq_pkg.sv
package iq_pkg;
  parameter int TAG_W = 7;
  typedef logic [TAG_W-1:0] tag_t;
endpackage

// File: rtl/iq_window.sv
// Window size in portions, limit-derived wakeup gating, youngest portion.
module iq_window #(
  parameter int PORTIONS = 16,
  parameter int PSIZE    = 8,
  localparam int DEPTH   = PORTIONS * PSIZE,
  localparam int IW      = $clog2(DEPTH),
  localparam int PW      = $clog2(PORTIONS),
  localparam int SW      = $clog2(PSIZE),
  localparam int WW      = $clog2(PORTIONS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grow,
  input  logic             shrink,
  input  logic [IW-1:0]    head,
  input  logic [DEPTH-1:0] occ_vld,
  output logic [WW-1:0]    win,
  output logic [IW:0]      win_entries,
  output logic [DEPTH-1:0] wake_en,
  output logic [PW-1:0]    youngest
);
  logic [WW-1:0] win_q;
  logic [IW-1:0] last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= WW'(PORTIONS);
    else if (grow && !shrink && (win_q < WW'(PORTIONS))) win_q <= win_q + 1'b1;
    else if (shrink && !grow && (win_q > WW'(1)))        win_q <= win_q - 1'b1;
  end

  assign win         = win_q;
  assign win_entries = (IW+1)'(int'(win_q) * PSIZE);
  assign last_w      = head + IW'(int'(win_q) * PSIZE - 1);
  assign youngest    = PW'(last_w >> SW);

  for (genvar i = 0; i < DEPTH; i++) begin : g_en
    wire [IW-1:0] off_w = IW'(i) - head;
    assign wake_en[i] = ({1'b0, off_w} < win_entries) | occ_vld[i];
  end
endmodule

// File: rtl/iq_select.sv
// Oldest-first picker: scans from the head, takes up to LANES ready slots.
module iq_select #(
  parameter int DEPTH = 128,
  parameter int LANES = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [IW-1:0]       head,
  input  logic [DEPTH-1:0]    rdy_vec,
  output logic [LANES-1:0]    sel_v,
  output logic [LANES*IW-1:0] sel_idx
);
  always_comb begin
    int n;
    logic [IW-1:0] idx;
    sel_v   = '0;
    sel_idx = '0;
    n       = 0;
    for (int j = 0; j < DEPTH; j++) begin
      idx = head + IW'(j);
      if (rdy_vec[idx] && (n < LANES)) begin
        sel_v[n]            = 1'b1;
        sel_idx[n*IW +: IW] = idx;
        n                   = n + 1;
      end
    end
  end
endmodule

// File: rtl/rsz_issue_queue.sv
module rsz_issue_queue
  import iq_pkg::*;
#(
  parameter int PORTIONS = 16,
  parameter int PSIZE    = 8,
  parameter int DISP_W   = 4,
  parameter int WB_W     = 4,
  parameter int ISS_W    = 4,
  localparam int DEPTH   = PORTIONS * PSIZE,
  localparam int IW      = $clog2(DEPTH),
  localparam int PW      = $clog2(PORTIONS),
  localparam int WW      = $clog2(PORTIONS + 1),
  localparam int CW      = $clog2(DISP_W + 1),
  localparam int LW      = (DISP_W > 1) ? $clog2(DISP_W) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dsp_valid,
  output logic                    dsp_ready,
  input  logic [CW-1:0]           dsp_cnt,
  input  logic [DISP_W*TAG_W-1:0] dsp_src1,
  input  logic [DISP_W-1:0]       dsp_src1_rdy,
  input  logic [DISP_W*TAG_W-1:0] dsp_src2,
  input  logic [DISP_W-1:0]       dsp_src2_rdy,
  input  logic [DISP_W*TAG_W-1:0] dsp_dst,
  input  logic [WB_W-1:0]         bc_valid,
  input  logic [WB_W*TAG_W-1:0]   bc_tag,
  input  logic                    iss_ready,
  output logic [ISS_W-1:0]        iss_valid,
  output logic [ISS_W*TAG_W-1:0]  iss_dst,
  input  logic                    grow,
  input  logic                    shrink,
  output logic [PW-1:0]           youngest_portion,
  output logic                    stall,
  output logic [IW:0]             occupancy,
  output logic [DEPTH-1:0]        wake_en
);
  logic [DEPTH-1:0] vld_q, s1_rdy_q, s2_rdy_q;
  tag_t             s1_tag_q [DEPTH];
  tag_t             s2_tag_q [DEPTH];
  tag_t             dst_q    [DEPTH];
  logic [IW-1:0]    head_q, tail;
  logic [IW:0]      occ_q, win_entries, hop;
  logic [WW-1:0]    win_cnt;
  logic [CW-1:0]    cnt_eff;
  logic             accept;
  logic [DEPTH-1:0] wr_en, clr, vnext;
  logic [LW-1:0]    wr_lane [DEPTH];
  logic [ISS_W-1:0]    sel_v;
  logic [ISS_W*IW-1:0] sel_idx;

  function automatic logic bc_hit(input tag_t t, input logic [WB_W-1:0] v,
                                  input logic [WB_W*TAG_W-1:0] tg);
    for (int j = 0; j < WB_W; j++)
      if (v[j] && (tg[j*TAG_W +: TAG_W] == t)) return 1'b1;
    return 1'b0;
  endfunction

  iq_window #(.PORTIONS(PORTIONS), .PSIZE(PSIZE)) u_win (
    .clk(clk), .rst_n(rst_n), .grow(grow), .shrink(shrink), .head(head_q),
    .occ_vld(vld_q), .win(win_cnt), .win_entries(win_entries),
    .wake_en(wake_en), .youngest(youngest_portion)
  );

  iq_select #(.DEPTH(DEPTH), .LANES(ISS_W)) u_sel (
    .head(head_q), .rdy_vec(vld_q & s1_rdy_q & s2_rdy_q),
    .sel_v(sel_v), .sel_idx(sel_idx)
  );

  assign tail      = head_q + occ_q[IW-1:0];
  assign dsp_ready = ({1'b0, occ_q} + (IW+2)'(DISP_W)) <= {1'b0, win_entries};
  assign stall     = ~dsp_ready;
  assign accept    = dsp_valid & dsp_ready;
  assign cnt_eff   = (dsp_cnt > CW'(DISP_W)) ? CW'(DISP_W) : dsp_cnt;
  assign occupancy = occ_q;
  assign iss_valid = sel_v;

  // Dispatch slot decode
  always_comb begin
    logic [IW-1:0] widx;
    wr_en = '0;
    for (int i = 0; i < DEPTH; i++) wr_lane[i] = '0;
    for (int k = 0; k < DISP_W; k++) begin
      widx = tail + IW'(k);
      if (accept && (k < int'(cnt_eff))) begin
        wr_en[widx]   = 1'b1;
        wr_lane[widx] = LW'(k);
      end
    end
  end

  // Issue lanes and slot release
  always_comb begin
    clr = '0;
    for (int k = 0; k < ISS_W; k++) begin
      iss_dst[k*TAG_W +: TAG_W] = dst_q[sel_idx[k*IW +: IW]];
      if (iss_ready && sel_v[k]) clr[sel_idx[k*IW +: IW]] = 1'b1;
    end
  end

  // Head skips freed slots among the old span
  assign vnext = vld_q & ~clr;
  always_comb begin
    logic found;
    found = 1'b0;
    hop   = occ_q;
    for (int j = 0; j < DEPTH; j++) begin
      if (!found && ((IW+1)'(j) < occ_q) && vnext[head_q + IW'(j)]) begin
        hop   = (IW+1)'(j);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= head_q + hop[IW-1:0];
      occ_q  <= occ_q - hop + (accept ? (IW+1)'(cnt_eff) : '0);
    end
  end

  // Entry storage with gated wakeup compare
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      s1_rdy_q <= '0;
      s2_rdy_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        s1_tag_q[i] <= '0;
        s2_tag_q[i] <= '0;
        dst_q[i]    <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en[i]) begin
          vld_q[i]    <= 1'b1;
          s1_tag_q[i] <= dsp_src1[wr_lane[i]*TAG_W +: TAG_W];
          s2_tag_q[i] <= dsp_src2[wr_lane[i]*TAG_W +: TAG_W];
          dst_q[i]    <= dsp_dst[wr_lane[i]*TAG_W +: TAG_W];
          s1_rdy_q[i] <= dsp_src1_rdy[wr_lane[i]] |
                         bc_hit(dsp_src1[wr_lane[i]*TAG_W +: TAG_W], bc_valid, bc_tag);
          s2_rdy_q[i] <= dsp_src2_rdy[wr_lane[i]] |
                         bc_hit(dsp_src2[wr_lane[i]*TAG_W +: TAG_W], bc_valid, bc_tag);
        end else begin
          if (clr[i]) vld_q[i] <= 1'b0;
          if (wake_en[i]) begin
            s1_rdy_q[i] <= s1_rdy_q[i] | bc_hit(s1_tag_q[i], bc_valid, bc_tag);
            s2_rdy_q[i] <= s2_rdy_q[i] | bc_hit(s2_tag_q[i], bc_valid, bc_tag);
          end
        end
      end
    end
  end
endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
  parameter int PORTIONS = 16,
  parameter int DISP_W   = 4,
  parameter int ISS_W    = 4,
  localparam int DEPTH   = PORTIONS * 8,
  localparam int IW      = $clog2(DEPTH),
  localparam int WW      = $clog2(PORTIONS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dsp_valid,
  input logic             dsp_ready,
  input logic             iss_ready,
  input logic [ISS_W-1:0] iss_valid,
  input logic             grow,
  input logic             shrink,
  input logic [IW:0]      occupancy,
  input logic [DEPTH-1:0] wake_en,
  input logic [DEPTH-1:0] wr_en,
  input logic [DEPTH-1:0] s1_rdy,
  input logic [DEPTH-1:0] s2_rdy,
  input logic [WW-1:0]    win
);
  // R2: occupancy rises only through an accepted dispatch, at most DISP_W
  a_r2_rise_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && dsp_ready) |=> (occupancy <= $past(occupancy) + DISP_W));
  a_r2_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !(dsp_valid && dsp_ready) |=> (occupancy <= $past(occupancy)));

  // R3: issue lanes fill from lane 0
  for (genvar k = 0; k + 1 < ISS_W; k++) begin : g_contig
    a_r3_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k+1] |-> iss_valid[k]);
  end

  // R6: window bounds and direction
  a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
    (win >= WW'(1)) && (win <= WW'(PORTIONS)));
  a_r6_shrink_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (shrink && !grow) |=> (win <= $past(win)));

  // R7: gated slots keep their ready bits
  for (genvar i = 0; i < DEPTH; i++) begin : g_gate
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!wake_en[i] && !wr_en[i]) |=> ($stable(s1_rdy[i]) && $stable(s2_rdy[i])));
  end

  // R9: without issue nothing leaves, whatever the window does
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |=> (occupancy >= $past(occupancy)));
endmodule

bind rsz_issue_queue iq_checker #(.PORTIONS(PORTIONS), .DISP_W(DISP_W), .ISS_W(ISS_W)) u_iq_chk (
  .clk(clk), .rst_n(rst_n), .dsp_valid(dsp_valid), .dsp_ready(dsp_ready),
  .iss_ready(iss_ready), .iss_valid(iss_valid), .grow(grow), .shrink(shrink),
  .occupancy(occupancy), .wake_en(wake_en), .wr_en(wr_en),
  .s1_rdy(s1_rdy_q), .s2_rdy(s2_rdy_q), .win(win_cnt)
);

// File: tb/tb_rsz_issue_queue.sv
`timescale 1ns/1ps
module tb_rsz_issue_queue;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         dsp_valid = 1'b0, dsp_ready;
  logic [2:0]   dsp_cnt = '0;
  logic [27:0]  dsp_src1 = '0, dsp_src2 = '0, dsp_dst = '0;
  logic [3:0]   dsp_src1_rdy = '0, dsp_src2_rdy = '0;
  logic [3:0]   bc_valid = '0;
  logic [27:0]  bc_tag = '0;
  logic         iss_ready = 1'b0;
  logic [3:0]   iss_valid;
  logic [27:0]  iss_dst;
  logic         grow = 1'b0, shrink = 1'b0;
  logic [3:0]   youngest_portion;
  logic         stall;
  logic [7:0]   occupancy;
  logic [127:0] wake_en;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [6:0] exp_q[$];

  always #2.5 clk = ~clk;

  rsz_issue_queue dut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_wake(input int head, input int win, input int occ);
    logic [127:0] v;
    for (int i = 0; i < 128; i++) begin
      int off;
      off  = (i - head + 128) % 128;
      v[i] = (off < win * 8) || (off < occ);
    end
    return v;
  endfunction

  // Monitor: compares every accepted issue with the scoreboard (R3)
  always @(negedge clk) begin
    if (rst_n && iss_ready) begin
      for (int k = 0; k < 4; k++) begin
        if (iss_valid[k]) begin
          if (exp_q.size() == 0) chk("R3 unexpected issue", 128'(iss_dst[k*7 +: 7]), 128'h7f);
          else chk("R3 issue order", 128'(iss_dst[k*7 +: 7]), 128'(exp_q.pop_front()));
        end
      end
    end
  end

  task automatic set_lane(input int k, input logic [6:0] s1, input logic r1,
                          input logic [6:0] s2, input logic r2, input logic [6:0] d);
    dsp_src1[k*7 +: 7] = s1; dsp_src1_rdy[k] = r1;
    dsp_src2[k*7 +: 7] = s2; dsp_src2_rdy[k] = r2;
    dsp_dst[k*7 +: 7]  = d;
  endtask

  task automatic fire(input int n);
    dsp_cnt = 3'(n); dsp_valid = 1'b1;
    @(posedge clk); #1 dsp_valid = 1'b0;
  endtask

  task automatic ready_group(input logic [6:0] base);
    for (int k = 0; k < 4; k++) set_lane(k, 7'd0, 1'b1, 7'd0, 1'b1, base + 7'(k));
  endtask

  task automatic pulse(input bit g, input bit s);
    grow = g; shrink = s;
    @(posedge clk); #1 grow = 1'b0; shrink = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic at_neg;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    at_neg();
    // R1 reset state
    chk("R1 occupancy", 128'(occupancy), 0);
    chk("R1 dsp_ready", 128'(dsp_ready), 1);
    chk("R1 stall", 128'(stall), 0);
    chk("R1 youngest", 128'(youngest_portion), 15);
    chk("R1 wake_en", wake_en, {128{1'b1}});
    @(posedge clk); #1;

    // R2/R3: four ready instructions issue in age order
    iss_ready = 1'b1;
    ready_group(7'd1);
    for (int d = 1; d <= 4; d++) exp_q.push_back(7'(d));
    fire(4);
    cycles(3);
    chk("R3 group drained", 128'(exp_q.size()), 0);

    // R2/R3/R4: held issue, oldest-first, wakeup by broadcast
    iss_ready = 1'b0;
    set_lane(0, 7'd40, 1'b0, 7'd0, 1'b1, 7'd10);
    set_lane(1, 7'd0, 1'b1, 7'd0, 1'b1, 7'd11);
    set_lane(2, 7'd0, 1'b1, 7'd0, 1'b1, 7'd12);
    fire(3);
    at_neg();
    chk("R2 occupancy after three", 128'(occupancy), 3);
    chk("R3 valid lanes", 128'(iss_valid), 4'b0011);
    chk("R3 lane0 oldest ready", 128'(iss_dst[6:0]), 11);
    chk("R3 lane1", 128'(iss_dst[13:7]), 12);
    @(posedge clk); #1;
    exp_q.push_back(7'd11); exp_q.push_back(7'd12);
    iss_ready = 1'b1;
    @(posedge clk); #1 iss_ready = 1'b0;
    at_neg();
    chk("R3 waiting entry not offered", 128'(iss_valid), 0);
    @(posedge clk); #1;
    bc_valid = 4'b1000; bc_tag[27:21] = 7'd40;
    @(posedge clk); #1 bc_valid = '0;
    exp_q.push_back(7'd10);
    iss_ready = 1'b1;
    cycles(3);
    chk("R4 woken entry issued", 128'(exp_q.size()), 0);
    chk("R10 empty after drain", 128'(occupancy), 0);

    // R5: dispatch and matching broadcast in one cycle
    set_lane(0, 7'd50, 1'b0, 7'd0, 1'b1, 7'd20);
    exp_q.push_back(7'd20);
    bc_valid = 4'b0100; bc_tag[20:14] = 7'd50;
    fire(1);
    bc_valid = '0;
    cycles(3);
    chk("R5 bypass wakeup", 128'(exp_q.size()), 0);
    // head is now 8

    // R6/R7: shrink to one portion, with saturation and a cancelled pair
    for (int i = 0; i < 16; i++) pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b1);
    at_neg();
    chk("R6 youngest at one portion", 128'(youngest_portion), 1);
    chk("R7 gate pattern", wake_en, exp_wake(8, 1, 0));
    @(posedge clk); #1;

    // R8: fill the single portion
    iss_ready = 1'b0;
    ready_group(7'd30); fire(4);
    at_neg();
    chk("R8 room for four", 128'(dsp_ready), 1);
    @(posedge clk); #1;
    ready_group(7'd34); fire(4);
    at_neg();
    chk("R8 stall when full", 128'(stall), 1);
    chk("R8 occupancy eight", 128'(occupancy), 8);
    @(posedge clk); #1;
    ready_group(7'd90);
    dsp_cnt = 3'd4; dsp_valid = 1'b1;
    cycles(2);
    dsp_valid = 1'b0;
    at_neg();
    chk("R8 refused group not taken", 128'(occupancy), 8);
    @(posedge clk); #1;

    // R6: grow one portion
    pulse(1'b1, 1'b0);
    at_neg();
    chk("R6 grow releases stall", 128'(dsp_ready), 1);
    chk("R6 youngest after grow", 128'(youngest_portion), 2);
    @(posedge clk); #1;
    ready_group(7'd38);
    set_lane(0, 7'd60, 1'b0, 7'd0, 1'b1, 7'd38);
    fire(4);

    // R9: shrink with slots 16..19 beyond the limit
    pulse(1'b0, 1'b1);
    at_neg();
    chk("R9 occupancy kept", 128'(occupancy), 12);
    chk("R7 occupied beyond limit enabled", wake_en, exp_wake(8, 1, 12));
    chk("R6 youngest after shrink", 128'(youngest_portion), 1);
    @(posedge clk); #1;
    bc_valid = 4'b0001; bc_tag[6:0] = 7'd60;
    @(posedge clk); #1 bc_valid = '0;
    for (int d = 30; d <= 41; d++) exp_q.push_back(7'(d));
    iss_ready = 1'b1;
    cycles(5);
    chk("R9 stranded entries issued", 128'(exp_q.size()), 0);
    at_neg();
    chk("R10 occupancy zero", 128'(occupancy), 0);
    chk("R10 youngest follows head", 128'(youngest_portion), 3);
    chk("R10 gate follows head", wake_en, exp_wake(20, 1, 0));
    @(posedge clk); #1;

    // R6: grow saturates at sixteen portions
    for (int i = 0; i < 20; i++) pulse(1'b1, 1'b0);
    at_neg();
    chk("R6 grow saturation", 128'(youngest_portion), 2);
    chk("R7 full window", wake_en, {128{1'b1}});

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule